// File: doc/BRIEF.md
# Pseudo-SRAM Power Sequencer

This block drives the two chip-enable lines of a pseudo-static memory while the memory is started, put to sleep and woken again. The active-low enable (`ce1_n`) selects the device for accesses. The active-high enable (`ce2`) is the power-control line: taking it low while `ce1_n` is high puts the memory into its lowest-power mode, and taking it high again starts the wake-up. The memory may not be accessed until both enables have been held high for a minimum hold time, which is several hundred microseconds. The block measures this hold with a prescaler that divides the clock into microsecond ticks, followed by a tick counter. The same hold follows every wake-up. A full sleep-and-wake pass therefore also serves as a reset of the memory when the first power-up wait was not met.

A supply-good input stands in for the analog supply ramp. The host asks for sleep and wake with single-cycle pulses. The access controller reports whether it is idle. While the memory is usable, the block grants that controller the `ce1_n` line. In every other state the block holds `ce1_n` high itself, withdraws the grant and asks for the data pins to be high impedance.

The state machine has six states:
- PWRUP_WAIT: the reset state.
- READY: the memory is usable.
- PD_SETUP: `ce1_n` is high before `ce2` falls.
- PD_HOLD: the minimum time `ce2` must stay low.
- PWR_DOWN: the memory is asleep.
- EXIT_WAIT: the hold after wake-up.

The transitions are:
- PWRUP_WAIT→READY when the hold has elapsed.
- READY→PD_SETUP on a sleep request with the controller idle.
- PD_SETUP→PD_HOLD after the setup cycles.
- PD_HOLD→PWR_DOWN after the minimum low time.
- PWR_DOWN→EXIT_WAIT on a wake request.
- EXIT_WAIT→READY when the hold has elapsed.
- Any state→PWRUP_WAIT when the supply is lost.

Top module: `psram_pwr_seq`

## Requirements
- R1: After `por_n` is asserted the block is in PWRUP_WAIT. In that state `ce1_n`=1, `ce2`=1, `grant`=0, `busy`=1, `ready`=0 and `dq_hiz`=1.
- R2: PWRUP_WAIT lasts exactly CYC_PER_US*HOLD_US consecutive cycles with `supply_good`=1, and READY follows in the next cycle. While `supply_good`=0 the hold count stays at zero.
- R3: In READY, `grant`=1, `ready`=1, `busy`=0, `ce2`=1 and `dq_hiz`=0. `ce1_n` follows `acc_ce1_n` in the same cycle.
- R4: A sleep request in READY with `ctl_idle`=1 moves the block to PD_SETUP in the next cycle. PD_SETUP lasts SETUP_CYC cycles with `ce1_n`=1, `ce2`=1 and `busy`=1.
- R5: PD_HOLD drives `ce2`=0 and `ce1_n`=1 with `busy`=1 for PDHOLD_CYC cycles. PWR_DOWN follows, with `ce2`=0, `ce1_n`=1, `busy`=0 and `ready`=0.
- R6: A sleep request that arrives while `ctl_idle`=0 is remembered. The block stays in READY with the grant held until `ctl_idle`=1, then enters PD_SETUP in the next cycle.
- R7: `wake_req` is accepted only in PWR_DOWN. A pulse in READY or during PD_HOLD has no effect and is not remembered, so the block stays in PWR_DOWN.
- R8: A wake request in PWR_DOWN enters EXIT_WAIT in the next cycle. EXIT_WAIT holds `ce2`=1 and `ce1_n`=1 for CYC_PER_US*HOLD_US cycles, and READY follows.
- R9: `supply_good`=0 in any state returns the block to PWRUP_WAIT in the next cycle.
- R10: `grant` is 1 and `dq_hiz` is 0 only in READY.
- R11: `ce2` falls only when `ce1_n` was already high in the previous cycle. `ce2` rises only while `ce1_n` is high. `ce2` is low only while `ce1_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| supply_good | input | 1 | Memory supply at or above its minimum (synchronous) |
| sleep_req | input | 1 | Host pulse requesting power-down |
| wake_req | input | 1 | Host pulse requesting power-down exit |
| ctl_idle | input | 1 | Access controller has no access in progress |
| acc_ce1_n | input | 1 | Access controller's chip enable 1 request, active low |
| ce1_n | output | 1 | Chip enable 1 to the memory, active low |
| ce2 | output | 1 | Chip enable 2 (power control) to the memory, active high |
| grant | output | 1 | `ce1_n` control passed to the access controller |
| busy | output | 1 | A timed sequence is in progress |
| ready | output | 1 | Memory is usable |
| dq_hiz | output | 1 | Data pins must be high impedance |

## Verification
The outputs decode the state register. A request applied in cycle k therefore shows its first effect in cycle k+1, except that `ce1_n` follows `acc_ce1_n` in the same cycle while in READY. The bench drives inputs just after each rising edge. For every stimulus it queues each expected output vector tagged with the absolute cycle in which that vector is due: k+1 for entering PD_SETUP, k+1+SETUP_CYC for `ce2` falling, k+1+SETUP_CYC+PDHOLD_CYC for PWR_DOWN, and k+CYC_PER_US*HOLD_US for READY after a hold that starts in cycle k. A monitor samples at the falling edge, compares exactly in that cycle, and also checks the last cycle before each change.

// File: rtl/psram_seq_pkg.sv
package psram_seq_pkg;

    typedef enum logic [2:0] {
        PWRUP_WAIT = 3'd0,
        READY      = 3'd1,
        PD_SETUP   = 3'd2,
        PD_HOLD    = 3'd3,
        PWR_DOWN   = 3'd4,
        EXIT_WAIT  = 3'd5
    } seq_state_t;

    // Bits needed to hold values 0 .. n-1, never less than one
    function automatic int cnt_width(input int n);
        return (n > 2) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/seq_prescaler.sv
// Divides the clock into one tick per DIV cycles; restarts on clr.
module seq_prescaler #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    import psram_seq_pkg::*;

    localparam int W = cnt_width(DIV);

    logic [W-1:0] cnt_q;

    assign tick = (cnt_q == W'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/seq_tick_counter.sv
// Counts prescaler ticks; done marks the tick that completes LIMIT of them.
module seq_tick_counter #(
    parameter int LIMIT = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic done
);
    import psram_seq_pkg::*;

    localparam int W = cnt_width(LIMIT);

    logic [W-1:0] cnt_q;

    assign done = tick && (cnt_q == W'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/seq_cyc_counter.sv
// Saturating cycle counter for the short nanosecond-scale intervals.
module seq_cyc_counter #(
    parameter int MAXV = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    output logic [$clog2(MAXV+1)-1:0]    count
);
    localparam int W = $clog2(MAXV + 1);

    logic [W-1:0] cnt_q;

    assign count = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (cnt_q != W'(MAXV))
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/psram_pwr_seq.sv
// Chip-enable sequencer for power-up, power-down entry and power-down exit.
module psram_pwr_seq #(
    parameter int CYC_PER_US = 100,  // clock cycles per microsecond
    parameter int HOLD_US    = 300,  // enables-high hold after power-up / exit
    parameter int SETUP_CYC  = 1,    // ce1_n high before ce2 falls (>=10 ns)
    parameter int PDHOLD_CYC = 8     // ce2 low minimum after entry (>=80 ns)
) (
    input  logic clk,
    input  logic por_n,
    input  logic supply_good,
    input  logic sleep_req,
    input  logic wake_req,
    input  logic ctl_idle,
    input  logic acc_ce1_n,
    output logic ce1_n,
    output logic ce2,
    output logic grant,
    output logic busy,
    output logic ready,
    output logic dq_hiz
);
    import psram_seq_pkg::*;

    localparam int SHORT_MAX = (SETUP_CYC > PDHOLD_CYC) ? SETUP_CYC : PDHOLD_CYC;
    localparam int SW        = $clog2(SHORT_MAX + 1);

    seq_state_t    state_q, state_d;
    logic          pend_q, pend_d;
    logic          tmr_clr;
    logic          us_tick;
    logic          hold_done;
    logic [SW-1:0] short_cnt;

    // ---------------- timers ----------------
    seq_prescaler #(.DIV(CYC_PER_US)) u_presc (
        .clk   (clk),
        .rst_n (por_n),
        .clr   (tmr_clr),
        .tick  (us_tick)
    );

    seq_tick_counter #(.LIMIT(HOLD_US)) u_hold (
        .clk   (clk),
        .rst_n (por_n),
        .clr   (tmr_clr),
        .tick  (us_tick),
        .done  (hold_done)
    );

    seq_cyc_counter #(.MAXV(SHORT_MAX)) u_short (
        .clk   (clk),
        .rst_n (por_n),
        .clr   (tmr_clr),
        .count (short_cnt)
    );

    // Timers restart on every state change and while power-up waits for supply
    assign tmr_clr = (state_d != state_q) ||
                     ((state_q == PWRUP_WAIT) && !supply_good);

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWRUP_WAIT: if (supply_good && hold_done)               state_d = READY;
            READY:      if ((sleep_req || pend_q) && ctl_idle)      state_d = PD_SETUP;
            PD_SETUP:   if (short_cnt == SW'(SETUP_CYC - 1))        state_d = PD_HOLD;
            PD_HOLD:    if (short_cnt == SW'(PDHOLD_CYC - 1))       state_d = PWR_DOWN;
            PWR_DOWN:   if (wake_req)                               state_d = EXIT_WAIT;
            EXIT_WAIT:  if (hold_done)                              state_d = READY;
            default:                                                state_d = PWRUP_WAIT;
        endcase
        if (!supply_good)
            state_d = PWRUP_WAIT;
    end

    // Sleep request waiting for the access controller to go idle
    always_comb begin
        if ((state_q == READY) && (state_d == READY))
            pend_d = pend_q || sleep_req;
        else
            pend_d = 1'b0;
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= PWRUP_WAIT;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        ce1_n  = 1'b1;
        ce2    = 1'b1;
        grant  = 1'b0;
        busy   = 1'b0;
        ready  = 1'b0;
        dq_hiz = 1'b1;
        unique case (state_q)
            PWRUP_WAIT: busy = 1'b1;
            READY: begin
                ce1_n  = acc_ce1_n;
                grant  = 1'b1;
                ready  = 1'b1;
                dq_hiz = 1'b0;
            end
            PD_SETUP:   busy = 1'b1;
            PD_HOLD: begin
                ce2  = 1'b0;
                busy = 1'b1;
            end
            PWR_DOWN:   ce2  = 1'b0;
            EXIT_WAIT:  busy = 1'b1;
            default:    busy = 1'b1;
        endcase
    end

endmodule

// File: rtl/psram_seq_chk.sv
// Protocol checker for the sequencer pins, attached by bind below.
module psram_seq_chk #(
    parameter int HOLD_TOTAL = 30000,
    parameter int PDHOLD_CYC = 8
) (
    input logic clk,
    input logic por_n,
    input logic supply_good,
    input logic wake_req,
    input logic ce1_n,
    input logic ce2,
    input logic grant,
    input logic busy,
    input logic ready,
    input logic dq_hiz
);
    logic [31:0] hi_run_q;   // consecutive cycles of both enables high with supply
    logic [31:0] lo_run_q;   // consecutive cycles of ce2 low

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            hi_run_q <= '0;
            lo_run_q <= '0;
        end else begin
            if (ce1_n && ce2 && supply_good)
                hi_run_q <= (hi_run_q == 32'hFFFF_FFFF) ? hi_run_q : hi_run_q + 1;
            else
                hi_run_q <= '0;
            if (!ce2)
                lo_run_q <= (lo_run_q == 32'hFFFF_FFFF) ? lo_run_q : lo_run_q + 1;
            else
                lo_run_q <= '0;
        end
    end

    p_hold_before_grant_r2: assert property (@(posedge clk) disable iff (!por_n)
        $rose(grant) |-> (hi_run_q >= 32'(HOLD_TOTAL)));

    p_grant_ce2_r3: assert property (@(posedge clk) disable iff (!por_n)
        grant |-> (ce2 && !busy && ready));

    p_pd_min_low_r5: assert property (@(posedge clk) disable iff (!por_n)
        ($rose(ce2) && $past(supply_good)) |-> (lo_run_q >= 32'(PDHOLD_CYC)));

    p_stay_down_r7: assert property (@(posedge clk) disable iff (!por_n)
        (!ce2 && !busy && !wake_req && supply_good) |=> (!ce2 && !busy));

    p_supply_loss_r9: assert property (@(posedge clk) disable iff (!por_n)
        !supply_good |=> (!grant && busy));

    p_hiz_r10: assert property (@(posedge clk) disable iff (!por_n)
        !ready |-> dq_hiz);

    p_ce2_fall_r11: assert property (@(posedge clk) disable iff (!por_n)
        $fell(ce2) |-> (ce1_n && $past(ce1_n)));

    p_ce2_rise_r11: assert property (@(posedge clk) disable iff (!por_n)
        $rose(ce2) |-> ce1_n);

    p_ce2_low_r11: assert property (@(posedge clk) disable iff (!por_n)
        !ce2 |-> ce1_n);

endmodule

bind psram_pwr_seq psram_seq_chk #(
    .HOLD_TOTAL (CYC_PER_US * HOLD_US),
    .PDHOLD_CYC (PDHOLD_CYC)
) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .supply_good (supply_good),
    .wake_req    (wake_req),
    .ce1_n       (ce1_n),
    .ce2         (ce2),
    .grant       (grant),
    .busy        (busy),
    .ready       (ready),
    .dq_hiz      (dq_hiz)
);

// File: tb/sim_psram_pwr_seq.sv
`timescale 1ns/1ps
module sim_psram_pwr_seq;

    localparam int CPU   = 4;
    localparam int HUS   = 5;
    localparam int SETC  = 2;
    localparam int PDH   = 8;
    localparam int HOLDT = CPU * HUS;

    // {ce1_n, ce2, grant, busy, ready, dq_hiz}
    localparam logic [5:0] V_WAIT = 6'b110101;  // PWRUP_WAIT, PD_SETUP, EXIT_WAIT
    localparam logic [5:0] V_RDY1 = 6'b111010;  // READY, acc_ce1_n = 1
    localparam logic [5:0] V_RDY0 = 6'b011010;  // READY, acc_ce1_n = 0
    localparam logic [5:0] V_HOLD = 6'b100101;  // PD_HOLD
    localparam logic [5:0] V_DOWN = 6'b100001;  // PWR_DOWN

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic supply_good = 1'b0;
    logic sleep_req = 1'b0;
    logic wake_req = 1'b0;
    logic ctl_idle = 1'b1;
    logic acc_ce1_n = 1'b1;
    logic ce1_n, ce2, grant, busy, ready, dq_hiz;

    always #5 clk = ~clk;

    psram_pwr_seq #(
        .CYC_PER_US (CPU),
        .HOLD_US    (HUS),
        .SETUP_CYC  (SETC),
        .PDHOLD_CYC (PDH)
    ) u0 (
        .clk         (clk),
        .por_n       (por_n),
        .supply_good (supply_good),
        .sleep_req   (sleep_req),
        .wake_req    (wake_req),
        .ctl_idle    (ctl_idle),
        .acc_ce1_n   (acc_ce1_n),
        .ce1_n       (ce1_n),
        .ce2         (ce2),
        .grant       (grant),
        .busy        (busy),
        .ready       (ready),
        .dq_hiz      (dq_hiz)
    );

    typedef struct {
        int unsigned when;
        logic [5:0]  vec;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    exp_t        cur;
    int unsigned cyc = 0;
    int          applied = 0;
    int          miscmp = 0;
    bit          finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Driver side: queue an expectation dly cycles from now
    task automatic expect_at(input int unsigned dly, input logic [5:0] v, input string tag);
        exp_t e;
        e.when = cyc + dly;
        e.vec  = v;
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // Monitor: compare due items at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].when <= cyc) begin
            cur = sb_q.pop_front();
            applied++;
            if (cur.when != cyc) begin
                miscmp++;
                $display("FAIL %s: item due in cycle %0d checked in cycle %0d, actual=%b expected=%b",
                         cur.tag, cur.when, cyc, {ce1_n, ce2, grant, busy, ready, dq_hiz}, cur.vec);
            end else if ({ce1_n, ce2, grant, busy, ready, dq_hiz} !== cur.vec) begin
                miscmp++;
                $display("FAIL %s: cycle %0d actual=%b expected=%b",
                         cur.tag, cyc, {ce1_n, ce2, grant, busy, ready, dq_hiz}, cur.vec);
            end
        end
    end

    initial begin
        step(3);
        por_n = 1'b1;
        expect_at(0, V_WAIT, "R1");
        expect_at(3, V_WAIT, "R2");              // no supply: hold not counting
        step(4);
        supply_good = 1'b1;                      // hold starts this cycle
        expect_at(HOLDT - 1, V_WAIT, "R2");
        expect_at(HOLDT, V_RDY1, "R2");
        step(HOLDT + 1);

        // R3: grant passes acc_ce1_n through combinationally
        acc_ce1_n = 1'b0;
        expect_at(0, V_RDY0, "R3");
        step();
        acc_ce1_n = 1'b1;
        expect_at(0, V_RDY1, "R3");
        wake_req = 1'b1;                          // R7: ignored in READY
        expect_at(1, V_RDY1, "R7");
        step();
        wake_req = 1'b0;
        step();

        // R6: sleep while controller busy is held
        ctl_idle  = 1'b0;
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
        expect_at(0, V_RDY1, "R6");
        expect_at(3, V_RDY1, "R6");
        step(4);
        ctl_idle = 1'b1;                          // cycle c
        expect_at(0, V_RDY1, "R6");
        expect_at(1, V_WAIT, "R4");
        expect_at(SETC, V_WAIT, "R4");
        expect_at(SETC + 1, V_HOLD, "R5");
        expect_at(SETC + PDH, V_HOLD, "R5");
        expect_at(SETC + PDH + 1, V_DOWN, "R5");
        step(5);                                   // c+5: inside PD_HOLD
        wake_req = 1'b1;                           // R7: ignored, not remembered
        step();
        wake_req = 1'b0;
        step(8);                                   // c+14
        expect_at(0, V_DOWN, "R7");
        expect_at(2, V_DOWN, "R7");
        step(3);

        // R8: wake from PWR_DOWN
        wake_req = 1'b1;
        expect_at(1, V_WAIT, "R8");
        expect_at(HOLDT, V_WAIT, "R8");
        expect_at(HOLDT + 1, V_RDY1, "R8");
        step();
        wake_req = 1'b0;
        step(HOLDT + 1);

        // R4 without waiting, then R9 during PD_HOLD
        sleep_req = 1'b1;
        expect_at(1, V_WAIT, "R4");
        step();
        sleep_req = 1'b0;
        step(4);                                   // s+5: PD_HOLD
        supply_good = 1'b0;
        expect_at(0, V_HOLD, "R9");
        expect_at(1, V_WAIT, "R9");
        step(3);
        expect_at(0, V_WAIT, "R9");
        supply_good = 1'b1;
        expect_at(HOLDT - 1, V_WAIT, "R2");
        expect_at(HOLDT, V_RDY1, "R10");
        step(HOLDT + 1);

        // R9 from READY
        supply_good = 1'b0;
        expect_at(0, V_RDY1, "R9");
        expect_at(1, V_WAIT, "R9");
        step(2);
        supply_good = 1'b1;
        expect_at(HOLDT, V_RDY1, "R9");
        step(HOLDT + 2);

        if (sb_q.size() != 0) begin
            miscmp++;
            $display("FAIL R1: %0d expectations never checked, actual=%0d expected=0",
                     sb_q.size(), sb_q.size());
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            miscmp++;
            $display("FAIL R1: watchdog expired, actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
            $finish;
        end
    end

endmodule